// File: doc/BRIEF.md
# Hardware Handshake Gate for a Serial Port

This block sits beside a UART datapath and runs both directions of the RTS/CTS handshake on its own. On the send side it watches the clear-to-send pin, which is low when the far end can accept data. When the pin goes high, the block closes a transmit gate. It closes only at a character boundary that the transmitter reports, so a frame already on the wire finishes with its stop bit. The gate opens again at the next boundary once the pin is back low.

On the receive side it drives the request-to-send pin from the receive FIFO fill level. When the level reaches a programmable limit, the pin goes high to ask the far end to pause. When automatic mode is off, the pin follows a software request bit instead. A single interrupt request flags flow-control events. It is cleared by a read of the interrupt status. The surrounding logic places this source at the lowest priority.

Top module: `flow_handshake_top`

## Requirements
- R1: While reset is held and on the first cycle after release, txEnable is 1, rtsN is 1 and flowIrq is 0.
- R2: One cycle after autoCtsEn is 0, txEnable is 1, whatever ctsN and frameEnd do.
- R3: With autoCtsEn set, ctsN is sampled through a two-flop synchronizer. A high level seen by the synchronizer clears txEnable on the clock edge where frameEnd is 1. On edges where frameEnd is 0, txEnable keeps its value.
- R4: After ctsN returns low, txEnable stays 0 until a clock edge with frameEnd 1. It is 1 after that edge.
- R5: With autoRtsEn set, rtsN is 1 one cycle after rxCount >= rxThresh and 0 one cycle after rxCount < rxThresh. Equality counts as full.
- R6: With autoRtsEn clear, rtsN equals the inverse of swRtsReq one cycle later, and rxCount has no effect on it.
- R7: With autoCtsEn and ctsIntEn set, a 0-to-1 change of ctsN sets flowIrq on the third clock edge after the pin changes. With ctsIntEn clear, the change leaves flowIrq at 0.
- R8: With autoRtsEn and rtsIntEn set, flowIrq is set on the same edge where rtsN rises. A rise of rtsN caused by swRtsReq does not set flowIrq.
- R9: statusRead clears flowIrq on the next edge. If a set event falls on the same edge, the set wins and flowIrq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| autoCtsEn | input | 1 | Enable automatic transmit gating from ctsN |
| autoRtsEn | input | 1 | Enable automatic rtsN from FIFO level |
| swRtsReq | input | 1 | Software request-to-send, 1 means assert (pin low) |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| frameEnd | input | 1 | Transmitter is idle or at the end of a stop bit |
| rxCount | input | CNT_W (6) | Receive FIFO fill level |
| rxThresh | input | CNT_W (6) | Fill level at which rtsN goes high |
| ctsIntEn | input | 1 | Enable interrupt on a CTS stop request |
| rtsIntEn | input | 1 | Enable interrupt on an automatic RTS deassertion |
| statusRead | input | 1 | Interrupt status read, clears flowIrq |
| txEnable | output | 1 | Transmitter may start a new character |
| rtsN | output | 1 | Request-to-send pin, active low |
| flowIrq | output | 1 | Flow-control interrupt request |

## Verification
The interrupt flag has a set path and a clear path that can land on the same edge. The bench provokes this by holding statusRead high while stepping rxCount up to the threshold at the same falling edge. It then judges that flowIrq stays 1 while rtsN rises, and that a later read alone drops it. A second overlap exists in the transmit gate: a frameEnd strobe can arrive while the CTS stop request is still inside the synchronizer. The bench times these strobes against the synchronizer latency, so the gate is seen to act only on the synchronized level.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef struct packed {
    logic gateLoad;   // update the transmit gate this cycle
    logic gateOpen;   // value loaded into the gate
    logic irqSet;     // raise the interrupt request
    logic irqClr;     // drop the interrupt request
  } flowStrobes_t;
endpackage

// File: rtl/flow_dp.sv
module flow_dp #(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctsN,
  input  logic                  autoRtsEn,
  input  logic                  swRtsReq,
  input  logic [CNT_W-1:0]      rxCount,
  input  logic [CNT_W-1:0]      rxThresh,
  input  flow_pkg::flowStrobes_t strb,
  output logic                  ctsSync,
  output logic                  ctsRise,
  output logic                  rtsNxt,
  output logic                  rtsQ,
  output logic                  gateQ,
  output logic                  irqQ
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic ctsPrev;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= ctsN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign ctsSync = syncChain[SYNC_STAGES-1];
  assign ctsRise = ctsSync & ~ctsPrev;
  assign rtsNxt  = autoRtsEn ? (rxCount >= rxThresh) : ~swRtsReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsPrev <= 1'b0;
      rtsQ    <= 1'b1;
      gateQ   <= 1'b1;
      irqQ    <= 1'b0;
    end else begin
      ctsPrev <= ctsSync;
      rtsQ    <= rtsNxt;
      if (strb.gateLoad) gateQ <= strb.gateOpen;
      if (strb.irqSet)      irqQ <= 1'b1;
      else if (strb.irqClr) irqQ <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl (
  input  logic                   autoCtsEn,
  input  logic                   autoRtsEn,
  input  logic                   frameEnd,
  input  logic                   ctsIntEn,
  input  logic                   rtsIntEn,
  input  logic                   statusRead,
  input  logic                   ctsSync,
  input  logic                   ctsRise,
  input  logic                   rtsNxt,
  input  logic                   rtsQ,
  output flow_pkg::flowStrobes_t strb
);
  logic ctsEvent;
  logic rtsEvent;

  always_comb begin
    ctsEvent      = autoCtsEn & ctsIntEn & ctsRise;
    rtsEvent      = autoRtsEn & rtsIntEn & rtsNxt & ~rtsQ;
    strb.gateLoad = frameEnd | ~autoCtsEn;
    strb.gateOpen = ~autoCtsEn | ~ctsSync;
    strb.irqSet   = ctsEvent | rtsEvent;
    strb.irqClr   = statusRead;
  end
endmodule

// File: rtl/flow_handshake_top.sv
module flow_handshake_top #(
  parameter int FIFO_DEPTH  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoCtsEn,
  input  logic             autoRtsEn,
  input  logic             swRtsReq,
  input  logic             ctsN,
  input  logic             frameEnd,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxThresh,
  input  logic             ctsIntEn,
  input  logic             rtsIntEn,
  input  logic             statusRead,
  output logic             txEnable,
  output logic             rtsN,
  output logic             flowIrq
);
  flow_pkg::flowStrobes_t strb;
  logic ctsSync, ctsRise, rtsNxt, rtsQ, gateQ, irqQ;

  flow_ctrl ctrl_i (
    .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn), .frameEnd(frameEnd),
    .ctsIntEn(ctsIntEn), .rtsIntEn(rtsIntEn), .statusRead(statusRead),
    .ctsSync(ctsSync), .ctsRise(ctsRise), .rtsNxt(rtsNxt), .rtsQ(rtsQ),
    .strb(strb)
  );

  flow_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .autoRtsEn(autoRtsEn),
    .swRtsReq(swRtsReq), .rxCount(rxCount), .rxThresh(rxThresh),
    .strb(strb), .ctsSync(ctsSync), .ctsRise(ctsRise), .rtsNxt(rtsNxt),
    .rtsQ(rtsQ), .gateQ(gateQ), .irqQ(irqQ)
  );

  assign txEnable = gateQ;
  assign rtsN     = rtsQ;
  assign flowIrq  = irqQ;
endmodule

// File: rtl/flow_handshake_chk.sv
module flow_handshake_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             autoCtsEn,
  input logic             autoRtsEn,
  input logic             swRtsReq,
  input logic             frameEnd,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] rxThresh,
  input logic             rtsIntEn,
  input logic             statusRead,
  input logic             txEnable,
  input logic             rtsN,
  input logic             flowIrq
);
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (txEnable && rtsN && !flowIrq));

  p_cts_off_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!autoCtsEn)) |-> txEnable);

  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(autoCtsEn) && $past(!frameEnd)) |-> $stable(txEnable));

  p_rts_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(autoRtsEn)) |-> (rtsN == ($past(rxCount) >= $past(rxThresh))));

  p_rts_soft_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!autoRtsEn)) |-> (rtsN == !$past(swRtsReq)));

  p_rts_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(rtsN) && $past(autoRtsEn) && $past(rtsIntEn)) |-> flowIrq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(flowIrq)) |-> $past(statusRead));
endmodule

bind flow_handshake_top flow_handshake_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn),
  .swRtsReq(swRtsReq), .frameEnd(frameEnd), .rxCount(rxCount),
  .rxThresh(rxThresh), .rtsIntEn(rtsIntEn), .statusRead(statusRead),
  .txEnable(txEnable), .rtsN(rtsN), .flowIrq(flowIrq)
);

// File: tb/flow_handshake_top_tb_top.sv
module flow_handshake_top_tb_top;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoCtsEn = 1'b0, autoRtsEn = 1'b0, swRtsReq = 1'b0;
  logic ctsN = 1'b0, frameEnd = 1'b0;
  logic [CW-1:0] rxCount = '0, rxThresh = '0;
  logic ctsIntEn = 1'b0, rtsIntEn = 1'b0, statusRead = 1'b0;
  logic txEnable, rtsN, flowIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flow_handshake_top dut_i (
    .clk(clk), .rstN(rstN), .autoCtsEn(autoCtsEn), .autoRtsEn(autoRtsEn),
    .swRtsReq(swRtsReq), .ctsN(ctsN), .frameEnd(frameEnd),
    .rxCount(rxCount), .rxThresh(rxThresh), .ctsIntEn(ctsIntEn),
    .rtsIntEn(rtsIntEn), .statusRead(statusRead),
    .txEnable(txEnable), .rtsN(rtsN), .flowIrq(flowIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_irq();
    statusRead = 1'b1; tick(1); statusRead = 1'b0;
  endtask

  task automatic test_reset();
    rstN = 1'b0; tick(3);
    check("R1", "txEnable in reset", txEnable, 1'b1);
    check("R1", "rtsN in reset", rtsN, 1'b1);
    check("R1", "flowIrq in reset", flowIrq, 1'b0);
    rstN = 1'b1; tick(1);
    check("R1", "txEnable after release", txEnable, 1'b1);
    check("R1", "rtsN after release", rtsN, 1'b1);
    check("R1", "flowIrq after release", flowIrq, 1'b0);
  endtask

  task automatic test_cts_off();
    autoCtsEn = 1'b0; ctsN = 1'b1; frameEnd = 1'b1; tick(5);
    check("R2", "gate open with auto CTS off", txEnable, 1'b1);
    frameEnd = 1'b0; ctsN = 1'b0; tick(4);
  endtask

  task automatic test_cts_stop_resume();
    autoCtsEn = 1'b1; ctsIntEn = 1'b1; frameEnd = 1'b0; ctsN = 1'b0; tick(4);
    clear_irq();
    ctsN = 1'b1; tick(2);
    check("R7", "irq not yet set after two edges", flowIrq, 1'b0);
    frameEnd = 1'b1; tick(1); frameEnd = 1'b0;
    check("R7", "irq set on third edge", flowIrq, 1'b1);
    check("R3", "gate closed at boundary after sync", txEnable, 1'b0);
    clear_irq();
    rstN = 1'b1;
    // frame-end strobe before the synchronizer sees the stop request
    autoCtsEn = 1'b0; tick(1); autoCtsEn = 1'b1; ctsN = 1'b0; tick(3);
    ctsN = 1'b1; frameEnd = 1'b1; tick(1); frameEnd = 1'b0;
    check("R3", "gate open when strobe precedes sync", txEnable, 1'b1);
    tick(4);
    check("R3", "gate holds without boundary", txEnable, 1'b1);
    frameEnd = 1'b1; tick(1); frameEnd = 1'b0;
    check("R3", "gate closes on boundary", txEnable, 1'b0);
    ctsN = 1'b0; tick(5);
    check("R4", "gate stays closed until boundary", txEnable, 1'b0);
    frameEnd = 1'b1; tick(1); frameEnd = 1'b0;
    check("R4", "gate reopens on boundary", txEnable, 1'b1);
    clear_irq();
  endtask

  task automatic test_cts_irq_masked();
    ctsIntEn = 1'b0; ctsN = 1'b0; tick(4); clear_irq();
    ctsN = 1'b1; tick(5);
    check("R7", "no irq when CTS interrupt disabled", flowIrq, 1'b0);
    ctsN = 1'b0; frameEnd = 1'b1; tick(4); frameEnd = 1'b0;
  endtask

  task automatic test_rts_auto();
    autoRtsEn = 1'b1; rtsIntEn = 1'b1; rxThresh = 6'd8; rxCount = 6'd7; tick(1);
    check("R5", "rtsN low below threshold", rtsN, 1'b0);
    clear_irq();
    rxCount = 6'd8; tick(1);
    check("R5", "rtsN high at threshold", rtsN, 1'b1);
    check("R8", "irq set with rtsN rise", flowIrq, 1'b1);
    clear_irq();
    check("R9", "read clears irq", flowIrq, 1'b0);
    rxCount = 6'd7; tick(1);
    check("R5", "rtsN low again below threshold", rtsN, 1'b0);
    rxCount = 6'd32; tick(1);
    check("R5", "rtsN high when full", rtsN, 1'b1);
    rxCount = 6'd0; rxThresh = 6'd0; tick(1);
    check("R5", "zero threshold keeps rtsN high", rtsN, 1'b1);
    rxThresh = 6'd8; rxCount = 6'd7; tick(1); clear_irq();
    statusRead = 1'b1; rxCount = 6'd8; tick(1); statusRead = 1'b0;
    check("R9", "set wins over same-cycle read", flowIrq, 1'b1);
    check("R5", "rtsN high in collision cycle", rtsN, 1'b1);
    clear_irq();
    check("R9", "later read clears irq", flowIrq, 1'b0);
  endtask

  task automatic test_rts_soft();
    autoRtsEn = 1'b0; swRtsReq = 1'b1; rxCount = 6'd32; tick(1);
    check("R6", "rtsN follows software request", rtsN, 1'b0);
    tick(2);
    check("R6", "full FIFO ignored in software mode", rtsN, 1'b0);
    clear_irq();
    swRtsReq = 1'b0; tick(1);
    check("R6", "rtsN high on software release", rtsN, 1'b1);
    check("R8", "software rise sets no irq", flowIrq, 1'b0);
    rxCount = 6'd0; tick(1);
    check("R6", "empty FIFO ignored in software mode", rtsN, 1'b1);
  endtask

  initial begin
    test_reset();
    test_cts_off();
    test_cts_stop_resume();
    test_cts_irq_masked();
    test_rts_auto();
    test_rts_soft();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule